// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches the enable and address of each port. When both ports are enabled on the same location, it decides which port may use that location. The port that loses receives an active-low busy flag, and its write request is held back inside the block. The winner keeps the location until it moves away or releases its enable. Then both flags are worked out again.

All inputs are sampled against one clock. A port "arrives" in the cycle where its enable or address differs from the value registered on the previous edge. When the ports begin to match, the port that did not move this cycle was there first and wins. When both moved in the same cycle, a tie rule picks the winner. By default the left port always wins a tie. A parameter changes this to alternating wins. The busy and write-enable outputs follow the current inputs in the same cycle, so no write can slip through on the first colliding cycle.

A mode input chooses the role. In master mode the block drives both busy flags actively high and low. In slave mode the busy flags from a master arrive on dedicated inputs and only gate the writes. The block's own busy outputs then stay inactive.

Top module: `collision_arbiter`

## Requirements
- R1: While the two addresses differ, or either enable is high, both busy outputs are high; this includes the reset state.
- R2: A collision (one busy output low in master mode) exists exactly when both enables are low and both addresses are equal.
- R3: When one port moves onto the address the other port already holds, the moving port gets busy low and the holding port keeps busy high.
- R4: The two busy outputs are never low together; when both ports move onto a common address in the same cycle, exactly one is low, and with ALT_PRIORITY=0 it is the right port.
- R5: With ALT_PRIORITY=1, successive same-cycle collisions alternate the winner, starting with the left port winning the first one after reset.
- R6: In master mode, a port's write enable is low whenever that port's busy output is low, regardless of its write request.
- R7: In slave mode both busy outputs stay high, and a low busy input on a port forces that port's write enable low; in master mode the busy inputs have no effect.
- R8: A winning port keeps the location while neither port changes enable or address; when the winner leaves (address change or enable high) the flags are re-evaluated in that same cycle.
- R9: A port's write enable equals its write request while its enable is low and it is not blocked, and is low whenever its enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1: drive busy flags; 0: take busy flags from inputs |
| lft_en_n | input | 1 | Left port enable, active low |
| lft_addr | input | ADDR_W | Left port address |
| lft_wr_req | input | 1 | Left port write request |
| lft_busy_in_n | input | 1 | Left busy flag from a master (slave mode) |
| rgt_en_n | input | 1 | Right port enable, active low |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_wr_req | input | 1 | Right port write request |
| rgt_busy_in_n | input | 1 | Right busy flag from a master (slave mode) |
| lft_busy_n | output | 1 | Left busy flag, active low |
| rgt_busy_n | output | 1 | Right busy flag, active low |
| lft_wr_en | output | 1 | Gated write enable to the array, left port |
| rgt_wr_en | output | 1 | Gated write enable to the array, right port |

## Verification
The hardest situations to reach are those where arrival order is decided by a single cycle. One case is two ports that step onto the same address in the same cycle. The other is a winner that leaves while the loser stays behind. The stimulus sets each port's enable and address one cycle at a time. It builds ties from a state with both ports disabled, and it builds ordered arrivals by holding one port steady while the other moves. A second instance with alternating priority sees the same stimulus, so a run of ties shows the winner alternating.

// File: rtl/cab_pkg.sv
package cab_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NUM_PORTS = 2;
    localparam int LEFT      = 0;
    localparam int RIGHT     = 1;
endpackage

// File: rtl/cab_port_track.sv
module cab_port_track #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic              moved
);
    typedef struct packed {
        logic              en_n;
        logic [ADDR_W-1:0] addr;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en_n = en_n;
        st_d.addr = addr;
        active    = !en_n;
        moved     = (en_n != st_q.en_n) || (addr != st_q.addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en_n <= 1'b1;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a port that was disabled on the last edge and is enabled now has moved
    assert_arrival_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_n) && !en_n) |-> moved);
endmodule

// File: rtl/cab_write_gate.sv
module cab_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic wr_req,
    input  logic active,
    input  logic lost,
    input  logic busy_in_n,
    output logic busy_out_n,
    output logic wr_en
);
    logic blocked;

    always_comb begin
        busy_out_n = master_mode ? !lost : 1'b1;
        blocked    = master_mode ? lost : !busy_in_n;
        wr_en      = wr_req && active && !blocked;
    end

    assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !busy_out_n) |-> !wr_en);
    assert_slave_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !busy_in_n) |-> !wr_en);
    assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> busy_out_n);
    assert_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !wr_en);
endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter
    import cab_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter bit ALT_PRIORITY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lft_en_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_wr_req,
    input  logic              lft_busy_in_n,
    input  logic              rgt_en_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_wr_req,
    input  logic              rgt_busy_in_n,
    output logic              lft_busy_n,
    output logic              rgt_busy_n,
    output logic              lft_wr_en,
    output logic              rgt_wr_en
);
    typedef struct packed {
        owner_e owner;
        logic   tie_turn;
    } arb_t;

    logic              en_n_v   [NUM_PORTS];
    logic [ADDR_W-1:0] addr_v   [NUM_PORTS];
    logic              wr_v     [NUM_PORTS];
    logic              bin_v    [NUM_PORTS];
    logic              bout_v   [NUM_PORTS];
    logic              wen_v    [NUM_PORTS];
    logic [NUM_PORTS-1:0] act;
    logic [NUM_PORTS-1:0] mov;
    logic [NUM_PORTS-1:0] lost;

    arb_t   arb_d, arb_q;
    owner_e owner_now;
    logic   match;
    logic   rearb;
    owner_e tie_pick;

    always_comb begin
        en_n_v[LEFT]  = lft_en_n;      en_n_v[RIGHT] = rgt_en_n;
        addr_v[LEFT]  = lft_addr;      addr_v[RIGHT] = rgt_addr;
        wr_v[LEFT]    = lft_wr_req;    wr_v[RIGHT]   = rgt_wr_req;
        bin_v[LEFT]   = lft_busy_in_n; bin_v[RIGHT]  = rgt_busy_in_n;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        cab_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_n   (en_n_v[p]),
            .addr   (addr_v[p]),
            .active (act[p]),
            .moved  (mov[p])
        );

        cab_write_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .wr_req      (wr_v[p]),
            .active      (act[p]),
            .lost        (lost[p]),
            .busy_in_n   (bin_v[p]),
            .busy_out_n  (bout_v[p]),
            .wr_en       (wen_v[p])
        );
    end

    // tie rule: fixed left, or alternating when the parameter asks for it
    if (ALT_PRIORITY) begin : g_alt
        assign tie_pick = arb_q.tie_turn ? OWN_RIGHT : OWN_LEFT;
    end else begin : g_fixed
        assign tie_pick = OWN_LEFT;
    end

    always_comb begin
        arb_d     = arb_q;
        match     = act[LEFT] && act[RIGHT] && (addr_v[LEFT] == addr_v[RIGHT]);
        rearb     = (arb_q.owner == OWN_NONE) || mov[LEFT] || mov[RIGHT];
        owner_now = arb_q.owner;
        if (!match) begin
            owner_now = OWN_NONE;
        end else if (rearb) begin
            if (mov[RIGHT] && !mov[LEFT]) begin
                owner_now = OWN_LEFT;
            end else if (mov[LEFT] && !mov[RIGHT]) begin
                owner_now = OWN_RIGHT;
            end else begin
                owner_now      = tie_pick;
                arb_d.tie_turn = !arb_q.tie_turn;
            end
        end
        arb_d.owner  = owner_now;
        lost[LEFT]   = (owner_now == OWN_RIGHT);
        lost[RIGHT]  = (owner_now == OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q.owner    <= OWN_NONE;
            arb_q.tie_turn <= 1'b0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign lft_busy_n = bout_v[LEFT];
    assign rgt_busy_n = bout_v[RIGHT];
    assign lft_wr_en  = wen_v[LEFT];
    assign rgt_wr_en  = wen_v[RIGHT];

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lft_busy_n && !rgt_busy_n));
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_en_n || rgt_en_n || (lft_addr != rgt_addr)) |-> (lft_busy_n && rgt_busy_n));
    assert_collision_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !lft_en_n && !rgt_en_n && (lft_addr == rgt_addr))
            |-> (lft_busy_n != rgt_busy_n));
    assert_later_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && match && mov[RIGHT] && !mov[LEFT]) |-> (!rgt_busy_n && lft_busy_n));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && match && !mov[LEFT] && !mov[RIGHT])
            |-> ($stable(lft_busy_n) && $stable(rgt_busy_n)));
endmodule

// File: tb/collision_arbiter_tb.sv
module collision_arbiter_tb;
    localparam int AW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_mode = 1'b1;
    logic l_en_n = 1'b1, r_en_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_wr = 1'b0, r_wr = 1'b0;
    logic l_bin = 1'b1, r_bin = 1'b1;

    logic d_lb, d_rb, d_lw, d_rw;
    logic a_lb, a_rb, a_lw, a_rw;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state, index 0 = fixed priority, 1 = alternating
    logic          p_l_en = 1'b1, p_r_en = 1'b1;
    logic [AW-1:0] p_l_ad = '0, p_r_ad = '0;
    int            own [2] = '{0, 0};
    int            tie [2] = '{0, 0};
    int            own_nx [2];

    always #10 clk = ~clk;

    collision_arbiter #(.ADDR_W(AW), .ALT_PRIORITY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_mode(m_mode),
        .lft_en_n(l_en_n), .lft_addr(l_addr), .lft_wr_req(l_wr), .lft_busy_in_n(l_bin),
        .rgt_en_n(r_en_n), .rgt_addr(r_addr), .rgt_wr_req(r_wr), .rgt_busy_in_n(r_bin),
        .lft_busy_n(d_lb), .rgt_busy_n(d_rb), .lft_wr_en(d_lw), .rgt_wr_en(d_rw));

    collision_arbiter #(.ADDR_W(AW), .ALT_PRIORITY(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .master_mode(m_mode),
        .lft_en_n(l_en_n), .lft_addr(l_addr), .lft_wr_req(l_wr), .lft_busy_in_n(l_bin),
        .rgt_en_n(r_en_n), .rgt_addr(r_addr), .rgt_wr_req(r_wr), .rgt_busy_in_n(r_bin),
        .lft_busy_n(a_lb), .rgt_busy_n(a_rb), .lft_wr_en(a_lw), .rgt_wr_en(a_rw));

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    // compute expected owner per variant from current inputs and reference history
    task automatic model_eval();
        bit match, lm, rm;
        match = !l_en_n && !r_en_n && (l_addr == r_addr);
        lm = (l_en_n != p_l_en) || (l_addr != p_l_ad);
        rm = (r_en_n != p_r_en) || (r_addr != p_r_ad);
        for (int v = 0; v < 2; v++) begin
            if (!match) own_nx[v] = 0;
            else if (own[v] != 0 && !lm && !rm) own_nx[v] = own[v];
            else if (rm && !lm) own_nx[v] = 1;
            else if (lm && !rm) own_nx[v] = 2;
            else own_nx[v] = (v == 1 && tie[v] % 2 == 1) ? 2 : 1;
        end
    endtask

    task automatic model_commit();
        bit match, lm, rm;
        match = !l_en_n && !r_en_n && (l_addr == r_addr);
        lm = (l_en_n != p_l_en) || (l_addr != p_l_ad);
        rm = (r_en_n != p_r_en) || (r_addr != p_r_ad);
        for (int v = 0; v < 2; v++) begin
            if (match && (own[v] == 0 || lm || rm) && (lm == rm)) tie[v]++;
            own[v] = own_nx[v];
        end
        p_l_en = l_en_n; p_r_en = r_en_n; p_l_ad = l_addr; p_r_ad = r_addr;
    endtask

    task automatic compare(input string req);
        logic el_b, er_b, el_w, er_w;
        model_eval();
        for (int v = 0; v < 2; v++) begin
            el_b = m_mode ? (own_nx[v] != 2) : 1'b1;
            er_b = m_mode ? (own_nx[v] != 1) : 1'b1;
            el_w = l_wr && !l_en_n && (m_mode ? (own_nx[v] != 2) : l_bin);
            er_w = r_wr && !r_en_n && (m_mode ? (own_nx[v] != 1) : r_bin);
            chk(req, v == 0 ? "fixed lft_busy_n" : "alt lft_busy_n", v == 0 ? d_lb : a_lb, el_b);
            chk(req, v == 0 ? "fixed rgt_busy_n" : "alt rgt_busy_n", v == 0 ? d_rb : a_rb, er_b);
            chk(req, v == 0 ? "fixed lft_wr_en" : "alt lft_wr_en", v == 0 ? d_lw : a_lw, el_w);
            chk(req, v == 0 ? "fixed rgt_wr_en" : "alt rgt_wr_en", v == 0 ? d_rw : a_rw, er_w);
        end
    endtask

    // apply inputs at the falling edge, compare mid-low phase, advance model at rising edge
    task automatic step(input logic mm, input logic len, input logic [AW-1:0] la, input logic lw,
                        input logic ren, input logic [AW-1:0] ra, input logic rw,
                        input logic lbi, input logic rbi, input string req);
        m_mode = mm; l_en_n = len; l_addr = la; l_wr = lw;
        r_en_n = ren; r_addr = ra; r_wr = rw; l_bin = lbi; r_bin = rbi;
        #5;
        compare(req);
        @(posedge clk);
        #1;
        model_commit();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        #5;
        compare("R1");               // reset state
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle and disabled cases
        step(1, 1, 15'd5, 1, 1, 15'd5, 1, 1, 1, "R1");
        step(1, 0, 15'd5, 1, 1, 15'd5, 1, 1, 1, "R2");
        step(1, 0, 15'd5, 1, 0, 15'd9, 1, 1, 1, "R9");
        // R3: right arrives later
        step(1, 0, 15'd5, 1, 0, 15'd5, 1, 1, 1, "R3");
        step(1, 0, 15'd5, 1, 0, 15'd5, 1, 1, 1, "R8");
        step(1, 0, 15'd5, 1, 0, 15'd6, 1, 1, 1, "R1");
        step(1, 0, 15'd5, 1, 0, 15'd5, 1, 1, 1, "R3");
        // R8: winner leaves by enable
        step(1, 1, 15'd5, 1, 0, 15'd5, 1, 1, 1, "R8");
        // R6: left arrives later and loses its write
        step(1, 0, 15'd5, 1, 0, 15'd5, 1, 1, 1, "R6");
        step(1, 0, 15'd5, 0, 0, 15'd5, 1, 1, 1, "R6");
        // R8: winner (right) moves away, left stays
        step(1, 0, 15'd5, 1, 0, 15'h7ffe, 1, 1, 1, "R8");
        // R4: both move onto one address together
        step(1, 0, 15'd7, 1, 0, 15'd7, 1, 1, 1, "R4");
        step(1, 1, 15'd7, 1, 1, 15'd7, 1, 1, 1, "R1");
        // R5: further ties alternate on the alternating instance
        step(1, 0, 15'd8, 1, 0, 15'd8, 1, 1, 1, "R5");
        step(1, 1, 15'd8, 1, 1, 15'd8, 1, 1, 1, "R5");
        step(1, 0, 15'd3, 1, 0, 15'd3, 1, 1, 1, "R5");
        step(1, 0, 15'd3, 1, 0, 15'd3, 1, 1, 1, "R8");
        step(1, 1, 15'd3, 1, 1, 15'd3, 1, 1, 1, "R1");
        step(1, 0, 15'h7fff, 1, 0, 15'h7fff, 1, 1, 1, "R5");
        // R7: slave mode
        step(0, 0, 15'h7fff, 1, 0, 15'h7fff, 1, 1, 1, "R7");
        step(0, 0, 15'h7fff, 1, 0, 15'h7fff, 1, 0, 1, "R7");
        step(0, 0, 15'd4, 1, 0, 15'd2, 1, 1, 0, "R7");
        // R7: busy inputs ignored in master mode
        step(1, 0, 15'd4, 1, 0, 15'd2, 1, 0, 0, "R7");
        // R9: disabled ports never write
        step(1, 1, 15'd4, 1, 1, 15'd2, 1, 1, 1, "R9");
        step(1, 0, 15'd4, 0, 0, 15'd2, 1, 1, 1, "R9");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule